// File: doc/BRIEF.md
# Token-Metered Shared Resource Allocator

This block rations access to shared targets (memory banks and the inbound and outbound sides of I/O ports) among a set of requestors. Software assigns every requestor to one of several allocation groups. For each pair of group and target, a token bucket fills at a programmed period and saturates at a programmed cap. A requestor that wants to issue a command to a target holds `req_valid` with the target index on `req_res`. It receives a one-cycle `grant` when a token for that target is available. The token comes from its own group's bucket first. Failing that, it is taken from the lowest-numbered other group that has a spare token for the target.

When the metering is switched off, every pending request is granted in the same cycle. A congestion input per target halves that target's token rate for every group. If requests stay pending on targets that have no tokens anywhere for a programmed number of consecutive cycles, a sticky over-commit interrupt rises, and it stays high until software clears it.

Top module: `token_alloc_mgr`

## Requirements
- R1: With the enable bit (bit 0 at address 0x00) clear, `grant` equals `req_valid` in the same cycle, and no token is consumed.
- R2: With the enable bit set, at most one requestor is granted per cycle, and only one with `req_valid` high. Target indices 0 to 15 are banks and 16 to 19 are I/O directions. A request naming an index of 20 or more is never granted.
- R3: The bucket for group g and target r gains one token every P cycles, where P is written at address 0x80 + 32*g + r. P = 0 stops generation and clears the period count.
- R4: A bucket never holds more tokens than the cap written at address 0x01 (bits 3:0).
- R5: An enabled grant happens only when some group holds a token for the requested target, and each grant removes exactly one token.
- R6: A requestor whose own group has no token for its target borrows from the lowest-numbered other group that has one.
- R7: Groups with eligible requestors are served round-robin, and requestors inside a group are served round-robin.
- R8: While `congested[r]` is high, every group's period for target r counts as 2P.
- R9: The interrupt sets after T consecutive cycles in which some enabled, in-range request targets a resource with zero tokens in all groups. T is written at address 0x02, and T = 0 disables the interrupt. Once set, it stays high until a write to address 0x03 clears it.
- R10: The group of requestor i is bits 1:0 of the register at address 0x20 + i.
- R11: After reset the block is disabled, every bucket is empty, every requestor is in group 0, all periods and the threshold are 0, the cap is 4, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 17 | Per-requestor pending request |
| req_res | input | 85 | Target index per requestor, 5 bits each, requestor i at bits 5i+4:5i |
| congested | input | 20 | Per-target congestion feedback |
| grant | output | 17 | Per-requestor grant, one cycle per consumed token |
| irq | output | 1 | Sticky over-commit interrupt |

## Verification
On every cycle the assertions check the following. The bypass path matches the requests while disabled. An enabled grant is single, pending and in range. Exactly one token leaves the buckets for each enabled grant. No bucket exceeds a settled cap. The interrupt holds until cleared. Token rates, congestion halving, the round-robin share between groups and within a group, borrowing from another group, and the interrupt threshold only show over many cycles. The bench's directed scenarios measure these by counting grants in fixed windows. The order in which other groups are drained when borrowing is not visible at the ports, so the bench covers only the fact that borrowing happens.

// File: rtl/tkm_pkg.sv
package tkm_pkg;
   // configuration address map
   localparam int unsigned TKM_A_CTRL     = 0;
   localparam int unsigned TKM_A_CAP      = 1;
   localparam int unsigned TKM_A_THR      = 2;
   localparam int unsigned TKM_A_ICLR     = 3;
   localparam int unsigned TKM_A_GRP      = 32;
   localparam int unsigned TKM_A_PER      = 128;
   localparam int unsigned TKM_PER_STRIDE = 32;

   // where the token for the current winner comes from
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_OWN    = 2'd1,
      SRC_BORROW = 2'd2
   } tkm_src_e;
endpackage

// File: rtl/tkm_cfg_regs.sv
module tkm_cfg_regs
   import tkm_pkg::*;
#(
   parameter int NUM_REQ = 17,
   parameter int NUM_GRP = 4,
   parameter int NUM_RES = 20,
   parameter int GRP_W   = 2,
   parameter int PER_W   = 8,
   parameter int CNT_W   = 4,
   parameter int THR_W   = 16,
   parameter int CAP_RST = 4,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       we,
   input  logic [ADDR_W-1:0]                          addr,
   input  logic [DATA_W-1:0]                          wdata,
   output logic                                       en,
   output logic [CNT_W-1:0]                           cap,
   output logic [THR_W-1:0]                           thr,
   output logic                                       irq_clr,
   output logic [NUM_REQ-1:0][GRP_W-1:0]              grp,
   output logic [NUM_GRP-1:0][NUM_RES-1:0][PER_W-1:0] per
);

   assign irq_clr = we && (addr == ADDR_W'(TKM_A_ICLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         cap <= CNT_W'(CAP_RST);
         thr <= '0;
         grp <= '0;
         per <= '0;
      end else if (we) begin
         if (addr == ADDR_W'(TKM_A_CTRL)) en  <= wdata[0];
         if (addr == ADDR_W'(TKM_A_CAP))  cap <= wdata[CNT_W-1:0];
         if (addr == ADDR_W'(TKM_A_THR))  thr <= wdata[THR_W-1:0];
         for (int i = 0; i < NUM_REQ; i++) begin
            if (addr == ADDR_W'(TKM_A_GRP + i)) grp[i] <= wdata[GRP_W-1:0];
         end
         for (int g = 0; g < NUM_GRP; g++) begin
            for (int r = 0; r < NUM_RES; r++) begin
               if (addr == ADDR_W'(TKM_A_PER + g * TKM_PER_STRIDE + r))
                  per[g][r] <= wdata[PER_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/tkm_bucket.sv
module tkm_bucket #(
   parameter int PER_W = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] period,
   input  logic [CNT_W-1:0] cap,
   input  logic             congested,
   input  logic             take,
   output logic [CNT_W-1:0] count
);

   logic [PER_W:0] div_q;
   logic [PER_W:0] limit;
   logic           add;
   logic [CNT_W:0] sum;

   always_comb begin
      limit = congested ? {period, 1'b0} : {1'b0, period};
      add   = (period != '0) && (div_q >= (limit - (PER_W+1)'(1)));
      sum   = {1'b0, count} + {{CNT_W{1'b0}}, add} - {{CNT_W{1'b0}}, take};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         count <= '0;
      end else begin
         if (period == '0 || add) div_q <= '0;
         else                     div_q <= div_q + (PER_W+1)'(1);
         count <= (sum > {1'b0, cap}) ? cap : sum[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/tkm_rr_pick.sv
module tkm_rr_pick #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt
);

   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] last_q;
   logic [IW-1:0] pick;
   logic          found;

   always_comb begin
      gnt   = '0;
      pick  = last_q;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = int'(last_q) + 1 + k;
         if (idx >= N) idx = idx - N;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            gnt[idx] = 1'b1;
            pick     = IW'(idx);
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            last_q <= IW'(N - 1);
      else if (adv && found) last_q <= pick;
   end

endmodule

// File: rtl/token_alloc_mgr.sv
module token_alloc_mgr
   import tkm_pkg::*;
#(
   parameter int NUM_REQ  = 17,
   parameter int NUM_GRP  = 4,
   parameter int NUM_BANK = 16,
   parameter int NUM_IO   = 2,
   parameter int PER_W    = 8,
   parameter int CNT_W    = 4,
   parameter int THR_W    = 16,
   parameter int CAP_RST  = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   localparam int NUM_RES = NUM_BANK + 2 * NUM_IO,
   localparam int RES_W   = $clog2(NUM_RES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic [DATA_W-1:0]          cfg_wdata,
   input  logic [NUM_REQ-1:0]         req_valid,
   input  logic [NUM_REQ*RES_W-1:0]   req_res,
   input  logic [NUM_RES-1:0]         congested,
   output logic [NUM_REQ-1:0]         grant,
   output logic                       irq
);

   localparam int GRP_W = $clog2(NUM_GRP);
   localparam int REQ_W = $clog2(NUM_REQ);

   // elaboration-time parameter checks
   if (NUM_GRP < 2 || NUM_GRP > 4) begin : g_bad_grp
      $error("token_alloc_mgr: NUM_GRP must be 2..4");
   end
   if (NUM_RES > TKM_PER_STRIDE) begin : g_bad_res
      $error("token_alloc_mgr: too many resources for the period map");
   end
   if (TKM_A_GRP + NUM_REQ > TKM_A_PER) begin : g_bad_req
      $error("token_alloc_mgr: too many requestors for the group map");
   end
   if (ADDR_W < 8 || DATA_W < THR_W || DATA_W < PER_W || DATA_W < CNT_W) begin : g_bad_w
      $error("token_alloc_mgr: bus widths too narrow");
   end

   logic                                        cfg_en;
   logic [CNT_W-1:0]                            cfg_cap;
   logic [THR_W-1:0]                            cfg_thr;
   logic                                        cfg_iclr;
   logic [NUM_REQ-1:0][GRP_W-1:0]               grp_of;
   logic [NUM_GRP-1:0][NUM_RES-1:0][PER_W-1:0]  cfg_per;

   tkm_cfg_regs #(
      .NUM_REQ(NUM_REQ), .NUM_GRP(NUM_GRP), .NUM_RES(NUM_RES), .GRP_W(GRP_W),
      .PER_W(PER_W), .CNT_W(CNT_W), .THR_W(THR_W), .CAP_RST(CAP_RST),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .en(cfg_en), .cap(cfg_cap), .thr(cfg_thr), .irq_clr(cfg_iclr),
      .grp(grp_of), .per(cfg_per)
   );

   // token buckets, one per group and target
   logic [NUM_GRP-1:0][NUM_RES-1:0][CNT_W-1:0] tok_cnt;
   logic [NUM_GRP-1:0][NUM_RES-1:0]            take;
   logic [NUM_GRP-1:0][NUM_RES-1:0]            nz;
   logic [NUM_RES-1:0]                         any_tok;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      for (genvar r = 0; r < NUM_RES; r++) begin : g_res
         tkm_bucket #(.PER_W(PER_W), .CNT_W(CNT_W)) bucket_i (
            .clk(clk), .rst_n(rst_n), .period(cfg_per[g][r]), .cap(cfg_cap),
            .congested(congested[r]), .take(take[g][r]), .count(tok_cnt[g][r])
         );
         assign nz[g][r] = (tok_cnt[g][r] != '0);
      end
   end

   always_comb begin
      any_tok = '0;
      for (int g = 0; g < NUM_GRP; g++) any_tok = any_tok | nz[g];
   end

   // request qualification
   logic [NUM_REQ-1:0][RES_W-1:0] res_of;
   logic [NUM_REQ-1:0]            in_rng;
   logic [NUM_REQ-1:0]            elig;

   assign res_of = req_res;

   always_comb begin
      for (int i = 0; i < NUM_REQ; i++) begin
         in_rng[i] = (int'(res_of[i]) < NUM_RES);
         elig[i]   = req_valid[i] && in_rng[i] && any_tok[res_of[i]];
      end
   end

   // two-level round-robin: across groups, then inside the chosen group
   logic [NUM_GRP-1:0][NUM_REQ-1:0] gm;
   logic [NUM_GRP-1:0][NUM_REQ-1:0] rsel;
   logic [NUM_GRP-1:0]              grp_any;
   logic [NUM_GRP-1:0]              gsel;
   logic [NUM_REQ-1:0]              win;
   logic                            win_any;

   always_comb begin
      for (int g = 0; g < NUM_GRP; g++) begin
         for (int i = 0; i < NUM_REQ; i++)
            gm[g][i] = elig[i] && (grp_of[i] == GRP_W'(g));
         grp_any[g] = |gm[g];
      end
   end

   tkm_rr_pick #(.N(NUM_GRP)) grp_arb_i (
      .clk(clk), .rst_n(rst_n), .req(grp_any), .adv(cfg_en && win_any), .gnt(gsel)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_arb
      tkm_rr_pick #(.N(NUM_REQ)) req_arb_i (
         .clk(clk), .rst_n(rst_n), .req(gm[g]),
         .adv(cfg_en && win_any && gsel[g]), .gnt(rsel[g])
      );
   end

   always_comb begin
      win = '0;
      for (int g = 0; g < NUM_GRP; g++) if (gsel[g]) win = win | rsel[g];
      win_any = |win;
   end

   // token source: own group, else lowest-numbered other group
   logic [REQ_W-1:0] widx;
   logic [RES_W-1:0] wres;
   logic [GRP_W-1:0] wgrp;
   logic [GRP_W-1:0] src;
   tkm_src_e         kind;

   always_comb begin
      widx = '0;
      for (int i = 0; i < NUM_REQ; i++) if (win[i]) widx = REQ_W'(i);
      wres = res_of[widx];
      wgrp = grp_of[widx];
      src  = wgrp;
      kind = SRC_NONE;
      if (win_any) begin
         if (nz[wgrp][wres]) begin
            kind = SRC_OWN;
         end else begin
            kind = SRC_BORROW;
            for (int g = NUM_GRP - 1; g >= 0; g--)
               if (GRP_W'(g) != wgrp && nz[g][wres]) src = GRP_W'(g);
         end
      end
      for (int g = 0; g < NUM_GRP; g++)
         for (int r = 0; r < NUM_RES; r++)
            take[g][r] = cfg_en && (kind != SRC_NONE) && (src == GRP_W'(g)) &&
                         (wres == RES_W'(r));
   end

   assign grant = cfg_en ? win : req_valid;

   // over-commit detection
   logic             starve;
   logic [THR_W-1:0] oc_q;
   logic [THR_W:0]   oc_inc;
   logic             irq_set;

   always_comb begin
      starve = 1'b0;
      for (int i = 0; i < NUM_REQ; i++)
         if (req_valid[i] && in_rng[i] && !any_tok[res_of[i]]) starve = 1'b1;
      starve  = starve && cfg_en;
      oc_inc  = {1'b0, oc_q} + (THR_W+1)'(1);
      irq_set = starve && (cfg_thr != '0) && (oc_inc == {1'b0, cfg_thr});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_q <= '0;
         irq  <= 1'b0;
      end else begin
         if (!starve)          oc_q <= '0;
         else if (~&oc_q)      oc_q <= oc_inc[THR_W-1:0];
         if (irq_set)          irq <= 1'b1;
         else if (cfg_iclr)    irq <= 1'b0;
      end
   end

endmodule

// File: rtl/tkm_checker.sv
module tkm_checker #(
   parameter int NUM_REQ = 17,
   parameter int NB      = 80,
   parameter int CNT_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                en,
   input logic [NUM_REQ-1:0]  req_valid,
   input logic [NUM_REQ-1:0]  grant,
   input logic [NUM_REQ-1:0]  res_ok,
   input logic                irq,
   input logic                irq_clr,
   input logic [CNT_W-1:0]    cap,
   input logic [NB*CNT_W-1:0] tok_cnt,
   input logic [NB-1:0]       take
);

   assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (grant == req_valid))
      else $error("bypass grant mismatch");

   assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> ($countones(grant) <= 1))
      else $error("more than one grant");

   assert_grant_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req_valid) == '0)
      else $error("grant without request");

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_rng
      assert_grant_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (en && grant[i]) |-> res_ok[i])
         else $error("grant for out-of-range target");
   end

   assert_one_token_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(take) == (en ? $countones(grant) : 0))
      else $error("token use does not match grants");

   for (genvar b = 0; b < NB; b++) begin : g_cap
      assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (cap == $past(cap)) |-> (tok_cnt[b*CNT_W +: CNT_W] <= cap))
         else $error("bucket above cap");
   end

   assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq)
      else $error("interrupt dropped without clear");

endmodule

bind token_alloc_mgr tkm_checker #(
   .NUM_REQ(NUM_REQ), .NB(NUM_GRP * NUM_RES), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .en(cfg_en), .req_valid(req_valid), .grant(grant),
   .res_ok(in_rng), .irq(irq), .irq_clr(cfg_iclr), .cap(cfg_cap),
   .tok_cnt(tok_cnt), .take(take)
);

// File: tb/token_alloc_mgr_tb_top.sv
module token_alloc_mgr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [7:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic [16:0] req_valid;
   logic [84:0] req_res;
   logic [19:0] congested;
   logic [16:0] grant;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   token_alloc_mgr dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_res(req_res),
      .congested(congested), .grant(grant), .irq(irq)
   );

   // bypass vectors: {stimulus, expected grant}
   localparam logic [33:0] TBL [6] = '{
      {17'h00001, 17'h00001},
      {17'h1FFFF, 17'h1FFFF},
      {17'h10000, 17'h10000},
      {17'h0AAAA, 17'h0AAAA},
      {17'h15555, 17'h15555},
      {17'h00000, 17'h00000}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = 8'(a);
      cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic set_req(input int i, input int r, input bit v);
      req_res[i*5 +: 5] = 5'(r);
      req_valid[i]      = v;
   endtask

   task automatic count_grants(input int idx, input int ncyc, output int n);
      n = 0;
      for (int c = 0; c < ncyc; c++) begin
         #1;
         if (grant[idx]) n++;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int n;
      int c0, c1, c2;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      req_valid = '0; req_res = '0; congested = '0;
      repeat (3) @(negedge clk);
      #1;
      check(grant == '0, "R11 reset grant", int'(grant), 0);
      check(irq == 1'b0, "R11 reset irq", int'(irq), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: disabled after reset, every request granted at once
      for (int k = 0; k < 6; k++) begin
         req_valid = TBL[k][33:17];
         #1;
         check(grant == TBL[k][16:0], "R1 bypass", int'(grant), int'(TBL[k][16:0]));
         @(negedge clk);
      end
      req_valid = '0;

      wr(0, 1);   // enable metering

      // R2: out-of-range target never granted
      wr(131, 1);
      set_req(0, 25, 1'b1);
      count_grants(0, 20, n);
      check(n == 0, "R2 out-of-range target", n, 0);
      set_req(0, 3, 1'b0);
      wr(131, 0);
      repeat (3) @(negedge clk);
      set_req(0, 3, 1'b1);          // drain leftover tokens
      repeat (8) @(negedge clk);
      set_req(0, 3, 1'b0);

      // R4/R5/R11: buckets saturate at the reset cap of 4
      wr(131, 3);
      repeat (40) @(negedge clk);
      wr(131, 0);
      repeat (2) @(negedge clk);
      set_req(0, 3, 1'b1);
      count_grants(0, 20, n);
      check(n == 4, "R4 R5 R11 saturated bucket", n, 4);

      // R3: one token every 5 cycles (tokens at cycles 5..95)
      wr(131, 5);
      count_grants(0, 100, n);
      check(n == 19, "R3 token rate", n, 19);
      wr(131, 0);
      repeat (5) @(negedge clk);

      // R8: congestion doubles the period
      congested[3] = 1'b1;
      wr(131, 5);
      count_grants(0, 100, n);
      check(n == 9, "R8 congested rate", n, 9);
      wr(131, 0);
      repeat (5) @(negedge clk);
      congested = '0;
      set_req(0, 3, 1'b0);

      // R7/R10: req2 moved to group 1; shares 3/3/6 over 12 cycles
      wr(34, 1);
      wr(131, 1);
      wr(132, 1);
      wr(133, 1);
      set_req(0, 3, 1'b1);
      set_req(1, 4, 1'b1);
      set_req(2, 5, 1'b1);
      repeat (6) @(negedge clk);
      c0 = 0; c1 = 0; c2 = 0;
      for (int c = 0; c < 12; c++) begin
         #1;
         if (grant[0]) c0++;
         if (grant[1]) c1++;
         if (grant[2]) c2++;
         @(negedge clk);
      end
      check(c0 == 3, "R7 R10 share req0", c0, 3);
      check(c1 == 3, "R7 R10 share req1", c1, 3);
      check(c2 == 6, "R7 R10 share req2", c2, 6);
      set_req(0, 3, 1'b0);
      set_req(1, 4, 1'b0);
      set_req(2, 5, 1'b0);
      wr(131, 0);
      wr(132, 0);
      wr(133, 0);

      // R6: group 1 requestor drains group 2's tokens
      wr(199, 1);
      repeat (10) @(negedge clk);
      wr(199, 0);
      repeat (3) @(negedge clk);
      wr(37, 1);
      set_req(5, 7, 1'b1);
      count_grants(5, 20, n);
      check(n == 4, "R6 borrowed tokens", n, 4);
      set_req(5, 7, 1'b0);
      repeat (3) @(negedge clk);

      // R9: interrupt after 10 starved cycles, cleared by write
      wr(2, 10);
      set_req(6, 9, 1'b1);
      repeat (9) @(negedge clk);
      #1;
      check(irq == 1'b0, "R9 irq before threshold", int'(irq), 0);
      @(negedge clk);
      #1;
      check(irq == 1'b1, "R9 irq at threshold", int'(irq), 1);
      @(negedge clk);
      wr(3, 0);
      #1;
      check(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
      repeat (5) @(negedge clk);
      #1;
      check(irq == 1'b0, "R9 irq stays clear", int'(irq), 0);
      set_req(6, 9, 1'b0);
      @(negedge clk);

      summary();
      $finish;
   end

endmodule